// File: doc/BRIEF.md
# LCD Multiplex Frame Sequencer

This block produces the logical timing skeleton for a multiplexed dot-matrix LCD. It is advanced by an oscillator-rate clock enable. Each frame walks through the common slots in order, at 128 enabled ticks per slot. A 64-tick key-scan slot then closes the frame before common 0 comes round again. Common 0 carries the pictograph segments, and the remaining commons carry the character rows. The duty select picks 8 or 15 common slots per frame. It also moves five dual-role pins from segment duty to common duty.

During the key-scan slot the block divides the period into equal windows, one for each key source. It drives the active source low on a one-cold strobe vector and pulses a sample strobe shortly before each window closes. Two further controls set how the panel is driven. Standby freezes the counters and forces every output to the idle level. An LCD-off control selects either the unselected waveform or the idle level while timing carries on. A per-frame polarity bit lets a downstream driver alternate waveform polarity.

For multi-chip panels, frame alignment uses an open-drain wired-OR sync line, which is brought out as a separate drive output and a sensed line input. A master pulls the line during the first tick of every frame. A slave realigns its counters to each rising edge it sees on the line.

Top module: `lcd_frame_seq`

## Requirements
- R1: With `duty15`=0 a frame is commons 0..7, and with `duty15`=1 it is commons 0..14. Each common slot lasts 128 enabled ticks. A key-scan slot of 64 enabled ticks follows, during which `scan_flag`=1 and `com_idx` keeps the last common's index. Common 0 follows the key-scan slot.
- R2: `com_sel` has exactly bit `com_idx` set during a common slot. It is all zero during the key-scan slot and in standby.
- R3: `dual_com` equals `duty15`, where 1 means the five dual-role pins act as commons.
- R4: During the key-scan slot, window w is the scan tick divided by 8. In window w, `ksrc_idx`=w and `ksrc_n` has bit w low with all other bits high. Outside the key-scan slot, `ksrc_n` is all ones and `ksrc_idx` is 0.
- R5: `key_sample` is high only during the key-scan slot, on an enabled tick whose position within its window is 6.
- R6: While `standby`=1 the counters and the polarity bit hold. In standby, `drive_mode`=2 (idle level), `scan_flag`=0, `com_sel`=0, `ksrc_n` is all ones, `sync_drive`=0, and a sync edge is ignored. On release, counting resumes from the held position.
- R7: With `lcd_off`=1 and no standby, `drive_mode` is 1 (unselected waveform) when `off_idle`=0 and 2 when `off_idle`=1, while timing and key scan continue. Otherwise `drive_mode`=0 (normal).
- R8: A master (`slave`=0) drives `sync_drive`=1 exactly while at common 0, tick 0, outside key scan and outside standby. A slave never drives it.
- R9: A slave that sees `sync_line`=1 on an enabled tick, after seeing it at 0 on the previous enabled tick, moves to common 0, tick 1, outside key scan. A master ignores `sync_line`.
- R10: `ac_phase` toggles each time a new frame begins: on the key-scan-to-common-0 wrap, or on a slave realign from any position other than common 0, tick 0.
- R11: A synchronous active-low reset yields common 0, tick 0, no key scan and `ac_phase`=0.
- R12: The counters advance only on clocks where `osc_en`=1.
- R13: When a common slot ends, the key-scan slot starts if that slot's index is at or above the last common of the current duty. This covers a duty shortened in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate tick enable |
| duty15 | input | 1 | 1: 15 common slots, 0: 8 |
| slave | input | 1 | 1: follow the sync line, 0: master |
| standby | input | 1 | Stop counting, force idle outputs |
| lcd_off | input | 1 | Force the display off |
| off_idle | input | 1 | Off style: 1 idle level, 0 unselected waveform |
| sync_line | input | 1 | Sensed level of the wired-OR sync line |
| sync_drive | output | 1 | Pull the sync line active (open-drain enable) |
| com_idx | output | 4 | Current or last common index |
| com_sel | output | 15 | One-hot select of the active common |
| dual_com | output | 1 | Dual-role pins act as commons |
| scan_flag | output | 1 | Key-scan slot in progress |
| ksrc_idx | output | 3 | Active key-source index |
| ksrc_n | output | 8 | One-cold key-source strobes |
| key_sample | output | 1 | Sample key inputs now |
| drive_mode | output | 2 | 0 normal, 1 unselected, 2 idle level |
| ac_phase | output | 1 | Per-frame polarity bit |

## Verification
The bench targets several corner cases, and each has a visible failure signature.

- **Key-scan entry.** The boundary from the last common into key scan is checked in both duties. A wrong terminal count shows up as a ninth or sixteenth common, or as a key slot of the wrong length.
- **Duty shortened mid-frame.** The duty is cut from 15 to 8 while common 10 is active. A design that compares for equality instead of at-or-above would run on to common 14.
- **Slave realign.** Sync pulses arrive both during key scan and in mid-slot. A realign that loads tick 0, or that toggles polarity twice at an aligned frame start, drifts by one tick or flips `ac_phase` out of step.
- **Standby and gapped enables.** Standby with a sync pulse present and sparse enables must leave the counters frozen. A design that ignored either input would move ahead of the reference.

// File: rtl/lcd_seq_pkg.sv
// Shared definitions for the LCD frame sequencer.
// Assumes: drive_mode encodings are decoded by the downstream pin drivers.
package lcd_seq_pkg;
    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_UNSEL  = 2'b01,
        DRV_IDLE   = 2'b10
    } drv_mode_e;
endpackage

// File: rtl/lcd_slot_timer.sv
// Frame counter: steps common slots and then the key-scan slot, realigns to
// the sync line in slave mode, and flips the polarity bit at each frame start.
// Assumes: KSCAN_CLKS <= SLOT_CLKS; osc_en is a one-clock tick enable.
module lcd_slot_timer #(
    parameter  int SLOT_CLKS  = 128,
    parameter  int KSCAN_CLKS = 64,
    parameter  int COMS_LONG  = 15,
    parameter  int COMS_SHORT = 8,
    localparam int CNT_W      = $clog2(SLOT_CLKS),
    localparam int COM_W      = $clog2(COMS_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             standby,
    input  logic             duty15,
    input  logic             slave,
    input  logic             sync_line,
    output logic [COM_W-1:0] com_idx,
    output logic [CNT_W-1:0] tick,
    output logic             kscan,
    output logic             ac_phase
);
    localparam logic [CNT_W-1:0] SLOT_LAST  = CNT_W'(SLOT_CLKS - 1);
    localparam logic [CNT_W-1:0] KS_LAST    = CNT_W'(KSCAN_CLKS - 1);
    localparam logic [COM_W-1:0] LONG_LAST  = COM_W'(COMS_LONG - 1);
    localparam logic [COM_W-1:0] SHORT_LAST = COM_W'(COMS_SHORT - 1);

    logic             line_q;
    logic             run;
    logic             sync_edge;
    logic             at_origin;
    logic             slot_end;
    logic [COM_W-1:0] last_com;

    // Decode the stepping conditions for this tick.
    always_comb begin
        run       = osc_en & ~standby;
        sync_edge = slave & sync_line & ~line_q;
        at_origin = (com_idx == '0) && (tick == '0) && !kscan;
        slot_end  = kscan ? (tick == KS_LAST) : (tick == SLOT_LAST);
        last_com  = duty15 ? LONG_LAST : SHORT_LAST;
    end

    // Advance slot/tick counters, track the sync line and the polarity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_idx  <= '0;
            tick     <= '0;
            kscan    <= 1'b0;
            ac_phase <= 1'b0;
            line_q   <= 1'b0;
        end else if (run) begin
            line_q <= sync_line;
            if (sync_edge) begin
                com_idx <= '0;
                tick    <= CNT_W'(1);
                kscan   <= 1'b0;
                if (!at_origin) ac_phase <= ~ac_phase;
            end else if (slot_end) begin
                tick <= '0;
                if (kscan) begin
                    kscan    <= 1'b0;
                    com_idx  <= '0;
                    ac_phase <= ~ac_phase;
                end else if (com_idx >= last_com) begin
                    kscan <= 1'b1;
                end else begin
                    com_idx <= com_idx + COM_W'(1);
                end
            end else begin
                tick <= tick + CNT_W'(1);
            end
        end
    end

    assert_tick_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        kscan |-> (tick <= KS_LAST));
    assert_scan_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kscan) |-> (tick == '0));
    assert_com_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        com_idx <= LONG_LAST);
    assert_frozen_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> $stable({com_idx, tick, kscan, ac_phase}));
    assert_no_tick_no_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> $stable({com_idx, tick, kscan, ac_phase}));
    assert_ac_at_frame_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_phase) |-> (com_idx == '0 && !kscan));
endmodule

// File: rtl/lcd_keyscan_decode.sv
// Key-scan decode: splits the key-scan slot into one window per key source,
// drives a one-cold strobe and pulses a sample strobe late in each window.
// Assumes: KSCAN_CLKS is NUM_KSRC times a power of two of at least 2.
module lcd_keyscan_decode #(
    parameter  int KSCAN_CLKS = 64,
    parameter  int NUM_KSRC   = 8,
    parameter  int CNT_W      = 7,
    localparam int KSRC_W     = $clog2(NUM_KSRC),
    localparam int WIN_CLKS   = KSCAN_CLKS / NUM_KSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_on,
    input  logic              osc_en,
    input  logic [CNT_W-1:0]  tick,
    output logic [KSRC_W-1:0] ksrc_idx,
    output logic [NUM_KSRC-1:0] ksrc_n,
    output logic              key_sample
);
    localparam logic [CNT_W-1:0] WIN_LEN  = CNT_W'(WIN_CLKS);
    localparam logic [CNT_W-1:0] SAMP_POS = CNT_W'(WIN_CLKS - 2);

    logic [CNT_W-1:0] win_full;
    logic [CNT_W-1:0] win_pos;

    // Window number and position inside the window.
    always_comb begin
        win_full   = tick / WIN_LEN;
        win_pos    = tick % WIN_LEN;
        ksrc_idx   = scan_on ? KSRC_W'(win_full) : '0;
        key_sample = scan_on & osc_en & (win_pos == SAMP_POS);
    end

    // One strobe per key source, low only for the active window.
    for (genvar k = 0; k < NUM_KSRC; k++) begin : g_src
        assign ksrc_n[k] = !(scan_on && (ksrc_idx == KSRC_W'(k)));
    end

    assert_one_cold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_on |-> ($countones(~ksrc_n) == 1));
    assert_idle_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_on |-> (ksrc_n == '1));
    assert_sample_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_sample |-> (scan_on && osc_en));
endmodule

// File: rtl/lcd_drive_ctrl.sv
// Output role control: common select, dual-pin role, drive mode and the
// master sync drive.
// Assumes: com_idx < NUM_COMS; standby overrides every other control.
module lcd_drive_ctrl #(
    parameter  int NUM_COMS = 15,
    parameter  int CNT_W    = 7,
    localparam int COM_W    = $clog2(NUM_COMS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standby,
    input  logic                lcd_off,
    input  logic                off_idle,
    input  logic                duty15,
    input  logic                slave,
    input  logic                kscan,
    input  logic [COM_W-1:0]    com_idx,
    input  logic [CNT_W-1:0]    tick,
    output logic [NUM_COMS-1:0] com_sel,
    output logic                dual_com,
    output logic                scan_flag,
    output logic                sync_drive,
    output logic [1:0]          drive_mode
);
    import lcd_seq_pkg::*;

    drv_mode_e mode;
    logic      com_phase;

    // Pick the pin drive style and the frame-level flags.
    always_comb begin
        if (standby)      mode = DRV_IDLE;
        else if (lcd_off) mode = off_idle ? DRV_IDLE : DRV_UNSEL;
        else              mode = DRV_NORMAL;
        drive_mode = mode;
        com_phase  = !kscan && !standby;
        scan_flag  = kscan && !standby;
        dual_com   = duty15;
        sync_drive = !slave && com_phase && (com_idx == '0) && (tick == '0);
    end

    // One select line per common.
    for (genvar c = 0; c < NUM_COMS; c++) begin : g_com
        assign com_sel[c] = com_phase && (com_idx == COM_W'(c));
    end

    assert_onehot_com_R2: assert property (@(posedge clk) disable iff (!rst_n)
        com_phase |-> ($countones(com_sel) == 1));
    assert_quiet_com_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !com_phase |-> (com_sel == '0));
    assert_standby_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (drive_mode == 2'b10 && !sync_drive && !scan_flag));
    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slave |-> !sync_drive);
endmodule

// File: rtl/lcd_frame_seq.sv
// Top: multiplexed LCD frame sequencer. Links the frame counter, key-scan
// decode and output role control.
// Assumes: one clk domain; osc_en marks oscillator ticks; sync_line is the
// sensed level of an external wired-OR line that sync_drive pulls.
module lcd_frame_seq #(
    parameter  int SLOT_CLKS  = 128,
    parameter  int KSCAN_CLKS = 64,
    parameter  int NUM_KSRC   = 8,
    parameter  int COMS_LONG  = 15,
    parameter  int COMS_SHORT = 8,
    localparam int CNT_W      = $clog2(SLOT_CLKS),
    localparam int COM_W      = $clog2(COMS_LONG),
    localparam int KSRC_W     = $clog2(NUM_KSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_en,
    input  logic                 duty15,
    input  logic                 slave,
    input  logic                 standby,
    input  logic                 lcd_off,
    input  logic                 off_idle,
    input  logic                 sync_line,
    output logic                 sync_drive,
    output logic [COM_W-1:0]     com_idx,
    output logic [COMS_LONG-1:0] com_sel,
    output logic                 dual_com,
    output logic                 scan_flag,
    output logic [KSRC_W-1:0]    ksrc_idx,
    output logic [NUM_KSRC-1:0]  ksrc_n,
    output logic                 key_sample,
    output logic [1:0]           drive_mode,
    output logic                 ac_phase
);
    logic [CNT_W-1:0] tick;
    logic             kscan;

    lcd_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS),
        .KSCAN_CLKS(KSCAN_CLKS),
        .COMS_LONG (COMS_LONG),
        .COMS_SHORT(COMS_SHORT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .standby  (standby),
        .duty15   (duty15),
        .slave    (slave),
        .sync_line(sync_line),
        .com_idx  (com_idx),
        .tick     (tick),
        .kscan    (kscan),
        .ac_phase (ac_phase)
    );

    lcd_keyscan_decode #(
        .KSCAN_CLKS(KSCAN_CLKS),
        .NUM_KSRC  (NUM_KSRC),
        .CNT_W     (CNT_W)
    ) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_on   (scan_flag),
        .osc_en    (osc_en),
        .tick      (tick),
        .ksrc_idx  (ksrc_idx),
        .ksrc_n    (ksrc_n),
        .key_sample(key_sample)
    );

    lcd_drive_ctrl #(
        .NUM_COMS(COMS_LONG),
        .CNT_W   (CNT_W)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .lcd_off   (lcd_off),
        .off_idle  (off_idle),
        .duty15    (duty15),
        .slave     (slave),
        .kscan     (kscan),
        .com_idx   (com_idx),
        .tick      (tick),
        .com_sel   (com_sel),
        .dual_com  (dual_com),
        .scan_flag (scan_flag),
        .sync_drive(sync_drive),
        .drive_mode(drive_mode)
    );
endmodule

// File: tb/lcd_frame_seq_bench.sv
// Bench: behavioural frame model (integers) compared with the design on
// every clock, plus directed checks around reset and slave realign.
module lcd_frame_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_en = 1'b1;
    logic duty15 = 1'b0, slave = 1'b0, standby = 1'b0;
    logic lcd_off = 1'b0, off_idle = 1'b0, tb_sync = 1'b0;
    logic sync_line, sync_drive, dual_com, scan_flag, key_sample, ac_phase;
    logic [3:0]  com_idx;
    logic [14:0] com_sel;
    logic [2:0]  ksrc_idx;
    logic [7:0]  ksrc_n;
    logic [1:0]  drive_mode;

    int n_cmp = 0, n_bad = 0;
    int gap = 0, gdiv = 0;
    bit finished = 0;

    // model state
    int m_com = 0, m_tick = 0, m_ks = 0, m_ac = 0, m_lineq = 0;

    always #5 clk = ~clk;

    assign sync_line = sync_drive | tb_sync;

    lcd_frame_seq u_lcd_frame_seq (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .duty15(duty15),
        .slave(slave), .standby(standby), .lcd_off(lcd_off),
        .off_idle(off_idle), .sync_line(sync_line), .sync_drive(sync_drive),
        .com_idx(com_idx), .com_sel(com_sel), .dual_com(dual_com),
        .scan_flag(scan_flag), .ksrc_idx(ksrc_idx), .ksrc_n(ksrc_n),
        .key_sample(key_sample), .drive_mode(drive_mode), .ac_phase(ac_phase)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int m_drive();
        return (!slave && !standby && m_com == 0 && m_tick == 0 && m_ks == 0) ? 1 : 0;
    endfunction

    // Reference model step on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_com = 0; m_tick = 0; m_ks = 0; m_ac = 0; m_lineq = 0;
        end else if (osc_en && !standby) begin
            int line, last, slot_len;
            line = (tb_sync || m_drive()) ? 1 : 0;
            last = duty15 ? 14 : 7;
            slot_len = m_ks ? 64 : 128;
            if (slave && line && !m_lineq) begin
                if (!(m_com == 0 && m_tick == 0 && m_ks == 0)) m_ac = 1 - m_ac;
                m_com = 0; m_tick = 1; m_ks = 0;
            end else if (m_tick == slot_len - 1) begin
                m_tick = 0;
                if (m_ks) begin m_ks = 0; m_com = 0; m_ac = 1 - m_ac; end
                else if (m_com >= last) m_ks = 1;
                else m_com = m_com + 1;
            end else begin
                m_tick = m_tick + 1;
            end
            m_lineq = line;
        end
    end

    // Compare every clock, shortly after the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            int scan, exp_ksrc, exp_mode, exp_sel;
            scan = (m_ks && !standby) ? 1 : 0;
            exp_ksrc = scan ? (8'hFF & ~(1 << (m_tick / 8))) : 8'hFF;
            exp_sel  = (!m_ks && !standby) ? (1 << m_com) : 0;
            exp_mode = standby ? 2 : (lcd_off ? (off_idle ? 2 : 1) : 0);
            chk("R1 R13 com_idx", com_idx, m_com);
            chk("R1 R12 scan_flag", scan_flag, scan);
            chk("R2 com_sel", com_sel, exp_sel);
            chk("R3 dual_com", dual_com, duty15);
            chk("R4 ksrc_n", ksrc_n, exp_ksrc);
            chk("R4 ksrc_idx", ksrc_idx, scan ? m_tick / 8 : 0);
            chk("R5 key_sample", key_sample, (scan && osc_en && (m_tick % 8) == 6) ? 1 : 0);
            chk("R6 R7 drive_mode", drive_mode, exp_mode);
            chk("R8 sync_drive", sync_drive, m_drive());
            chk("R10 ac_phase", ac_phase, m_ac);
        end
    end

    // Gapped enable generator: one tick in three when gap is set.
    always @(negedge clk) begin
        if (gap) begin
            gdiv = (gdiv + 1) % 3;
            osc_en = (gdiv == 0);
        end else begin
            osc_en = 1'b1;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #1900000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        run(5);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R11 reset com_idx", com_idx, 0);
        chk("R11 reset scan_flag", scan_flag, 0);
        chk("R11 reset ac_phase", ac_phase, 0);
        run(2300);                     // R1 8-duty frames
        @(negedge clk); duty15 = 1'b1;
        run(4100);                     // R1 15-duty frames
        gap = 1; run(3500); gap = 0;   // R12 sparse enables
        @(negedge clk); lcd_off = 1'b1; run(300);   // R7
        off_idle = 1'b1; run(300);
        lcd_off = 1'b0; off_idle = 1'b0;
        standby = 1'b1; run(400);      // R6
        standby = 1'b0; run(200);
        // R13: shorten duty while common 10 is active
        do @(negedge clk); while (!(com_idx == 4'd10 && !scan_flag));
        duty15 = 1'b0; run(600);
        // R9: slave realign during key scan
        slave = 1'b1;
        do @(negedge clk); while (!scan_flag);
        run(5);
        tb_sync = 1'b1;
        @(posedge clk); #3;
        chk("R9 realign scan_flag", scan_flag, 0);
        chk("R9 realign com_idx", com_idx, 0);
        @(negedge clk); tb_sync = 1'b0;
        run(700);
        tb_sync = 1'b1; run(3); tb_sync = 1'b0;  // mid-slot realign
        run(1500);
        standby = 1'b1; run(5); tb_sync = 1'b1; run(3); tb_sync = 1'b0;
        run(5); standby = 1'b0; run(300);        // R6 edge ignored
        slave = 1'b0; run(1200);
        rst_n = 1'b0; run(3); rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R11 re-reset com_idx", com_idx, 0);
        chk("R11 re-reset ac_phase", ac_phase, 0);
        run(100);
        summary();
    end
endmodule